// File: doc/BRIEF.md
# Video Display Processor Access Sequencer

This block sits between a simple request port and an 8-bit video display processor. It turns each read or write request into one correctly timed chip-select strobe. A write uses the write strobe and a read uses the read strobe. The two-bit port number drives the device's mode pins. Every strobe-width, recovery and reset figure is given in nanoseconds and converted to clock cycles from a clock-frequency parameter (in kHz). The block therefore keeps the same real-time behaviour at any system clock.

After reset the block drives the device's reset input low for a short, well-defined time, about 10 us, and then opens the request port. Each access holds its strobe for a minimum width. It is then followed by a recovery gap before the next strobe may start. The gap is long (8 us) after an access to the memory-data port (port 0) and short (2 us) after any other port. The device has an optional wait output, active low. A strobe is stretched while that output is low, but only when the device has been told to drive it. The block learns this by watching the two-byte register-write sequences sent to the control port (port 1). It keeps its own copy of bit 2 of register 25.

The request side is valid/ready. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. `req_ready` stays low from the reset pulse through every strobe and recovery gap. A source must hold its request and fields stable until it is taken; a held request is taken exactly once. The response is a one-cycle `rsp_valid` pulse with no back-pressure. The consumer must be able to take it in any cycle.

Top module: `vid_access_seq`

## Requirements
- R1: From reset, `vid_reset_n` is low and stays low for exactly RESET_NS converted to cycles after `rst` is released (2000 cycles at 200 MHz). Throughout that time `req_ready` is low and both strobes are high (inactive).
- R2: `req_ready` is low whenever a strobe is active. A request held valid while the block is busy is taken once when `req_ready` returns, and the number of strobes equals the number of requests taken.
- R3: A write (`req_write`=1) drives `vid_wr_n` low for exactly STROBE_NS in cycles (20 at 200 MHz) when no wait stretch applies. `vid_mode` equals the request port and `vid_dout` equals the request data, both stable while the strobe is low.
- R4: A read drives `vid_rd_n` low for the same width. `rsp_rdata` takes the value of `vid_din` on the last clock edge of the strobe, and `rsp_valid` is high for one cycle, the first cycle after the strobe ends.
- R5: Every write also gives a one-cycle `rsp_valid` pulse after its strobe, and a write leaves `rsp_rdata` unchanged.
- R6: After an access to port 0 the next strobe starts no sooner than LONG_GAP_NS in cycles (1600); after ports 1 to 3 no sooner than SHORT_GAP_NS in cycles (400). With a request already waiting, the strobe is inactive for exactly gap+1 cycles.
- R7: `vid_wr_n` and `vid_rd_n` are never low at the same time.
- R8: Two consecutive writes to port 1 set the wait-enable copy. If the second byte has bits [7:6]=2'b10 and bits [5:0]=25 (0x99), wait enable takes bit 2 of the first byte. A second byte naming any other register leaves it unchanged. A read of port 1 restarts the byte pairing.
- R9: With wait disabled (the state after reset), `vid_wait_n` has no effect, and strobe width stays the nominal value while it is low.
- R10: With wait enabled, the strobe is stretched one cycle for each cycle the synchronized `vid_wait_n` (two flops) is low. Releasing the wait K cycles into the strobe gives a width between nominal+K and nominal+K+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_port | input | 2 | Device port number, driven to the mode pins |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Data from the most recent read |
| vid_reset_n | output | 1 | Device reset, active low |
| vid_wr_n | output | 1 | Device write strobe, active low |
| vid_rd_n | output | 1 | Device read strobe, active low |
| vid_mode | output | 2 | Device mode (port select) pins |
| vid_dout | output | 8 | Data to the device |
| vid_din | input | 8 | Data from the device |
| vid_wait_n | input | 1 | Device wait output, active low |

## Verification
The hardest situation to reach is a strobe stretched by the device's wait line. Wait enable has no pin: it changes only when a byte pair on port 1 is recognised as a write to register 25. So the stimulus first sends the exact pairs that enable it, disable it, and leave it alone. It also sends a pair broken by a status read, which only enables wait if the pairing restarts. While holding `vid_wait_n` low, it releases the line a known number of cycles into a strobe, and checks the measured width against the synchronizer latency in each enable state.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
  typedef enum logic [1:0] {ST_RST, ST_IDLE, ST_STROBE, ST_GAP} seq_state_e;

  localparam logic [1:0] PORT_DATA = 2'd0;
  localparam logic [1:0] PORT_CTRL = 2'd1;
  localparam logic [5:0] WAIT_REG  = 6'd25;
  localparam int         WAIT_BIT  = 2;

  // Round a duration in ns up to whole cycles at clk_khz; at least one cycle.
  function automatic int ns_to_cycles(input longint ns, input longint clk_khz);
    longint t;
    t = (ns * clk_khz + 64'd999999) / 64'd1000000;
    if (t < 1) t = 1;
    return int'(t);
  endfunction
endpackage

// File: rtl/vseq_sync.sv
module vseq_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q = d;
    end else begin : g_chain
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RESET_VAL}};
        else     chain <= {chain[STAGES-2+((STAGES==1)?1:0):0], d} ;
      end
      assign q = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/vseq_wait_shadow.sv
module vseq_wait_shadow
  import vseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_ctl,   // write to control port taken this cycle
  input  logic       rd_ctl,   // read of control port taken this cycle
  input  logic [7:0] byte_in,
  output logic       wait_en
);
  logic second;     // next control write is the second byte of a pair
  logic held_bit;   // wait bit carried by the first byte

  always_ff @(posedge clk) begin
    if (rst) begin
      second   <= 1'b0;
      held_bit <= 1'b0;
      wait_en  <= 1'b0;
    end else if (rd_ctl) begin
      second <= 1'b0;
    end else if (wr_ctl) begin
      if (!second) begin
        held_bit <= byte_in[WAIT_BIT];
        second   <= 1'b1;
      end else begin
        second <= 1'b0;
        if (byte_in[7:6] == 2'b10 && byte_in[5:0] == WAIT_REG)
          wait_en <= held_bit;
      end
    end
  end

  AST_WAITEN_ONLY_ON_PAIR: assert property (@(posedge clk) disable iff (rst)
    (wait_en != $past(wait_en)) |-> $past(wr_ctl && second)) // R8
    else $error("wait enable changed outside a register write pair");
endmodule

// File: rtl/vid_access_seq.sv
module vid_access_seq
  import vseq_pkg::*;
#(
  parameter int CLK_KHZ      = 200000,
  parameter int STROBE_NS    = 100,
  parameter int SHORT_GAP_NS = 2000,
  parameter int LONG_GAP_NS  = 8000,
  parameter int RESET_NS     = 10000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic       req_write,
  input  logic [1:0] req_port,
  input  logic [7:0] req_wdata,
  output logic       rsp_valid,
  output logic [7:0] rsp_rdata,
  output logic       vid_reset_n,
  output logic       vid_wr_n,
  output logic       vid_rd_n,
  output logic [1:0] vid_mode,
  output logic [7:0] vid_dout,
  input  logic [7:0] vid_din,
  input  logic       vid_wait_n
);
  localparam int STB_CYC   = ns_to_cycles(STROBE_NS, CLK_KHZ);
  localparam int SHORT_CYC = ns_to_cycles(SHORT_GAP_NS, CLK_KHZ);
  localparam int LONG_CYC  = ns_to_cycles(LONG_GAP_NS, CLK_KHZ);
  localparam int RST_CYC   = ns_to_cycles(RESET_NS, CLK_KHZ);
  localparam int MAX_AB    = (STB_CYC > SHORT_CYC) ? STB_CYC : SHORT_CYC;
  localparam int MAX_CD    = (LONG_CYC > RST_CYC) ? LONG_CYC : RST_CYC;
  localparam int MAX_CYC   = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CW        = $clog2(MAX_CYC + 1);

  seq_state_e    st;
  logic [CW-1:0] cnt;
  logic          op_wr;
  logic [1:0]    op_port;
  logic [7:0]    op_data;
  logic          wait_s;
  logic          wait_en;
  logic          accept;
  logic          stall;
  logic          strobe_on;

  assign accept = req_valid && req_ready;
  assign stall  = wait_en && !wait_s;

  vseq_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_wsync (
    .clk(clk), .rst(rst), .d(vid_wait_n), .q(wait_s)
  );

  vseq_wait_shadow u_shadow (
    .clk(clk), .rst(rst),
    .wr_ctl(accept && req_write && req_port == PORT_CTRL),
    .rd_ctl(accept && !req_write && req_port == PORT_CTRL),
    .byte_in(req_wdata),
    .wait_en(wait_en)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_RST;
      cnt       <= CW'(RST_CYC - 1);
      op_wr     <= 1'b0;
      op_port   <= 2'd0;
      op_data   <= 8'd0;
      rsp_valid <= 1'b0;
      rsp_rdata <= 8'd0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (st)
        ST_RST: begin
          if (cnt == '0) st <= ST_IDLE;
          else           cnt <= cnt - 1'b1;
        end
        ST_IDLE: begin
          if (accept) begin
            st      <= ST_STROBE;
            cnt     <= CW'(STB_CYC - 1);
            op_wr   <= req_write;
            op_port <= req_port;
            op_data <= req_wdata;
          end
        end
        ST_STROBE: begin
          if (!stall) begin
            if (cnt == '0) begin
              st        <= ST_GAP;
              cnt       <= (op_port == PORT_DATA) ? CW'(LONG_CYC - 1) : CW'(SHORT_CYC - 1);
              rsp_valid <= 1'b1;
              if (!op_wr) rsp_rdata <= vid_din;
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
        end
        ST_GAP: begin
          if (cnt == '0) st <= ST_IDLE;
          else           cnt <= cnt - 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign req_ready   = (st == ST_IDLE);
  assign vid_reset_n = (st != ST_RST);
  assign vid_wr_n    = !(st == ST_STROBE && op_wr);
  assign vid_rd_n    = !(st == ST_STROBE && !op_wr);
  assign vid_mode    = op_port;
  assign vid_dout    = op_data;
  assign strobe_on   = !vid_wr_n || !vid_rd_n;

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    !vid_reset_n |-> (vid_wr_n && vid_rd_n && !req_ready)) // R1
    else $error("activity during device reset");
  AST_BUSY_IN_STROBE: assert property (@(posedge clk) disable iff (rst)
    strobe_on |-> !req_ready) // R2
    else $error("ready during strobe");
  AST_STROBE_FIELDS_STABLE: assert property (@(posedge clk) disable iff (rst)
    (strobe_on && $past(strobe_on)) |-> ($stable(vid_mode) && $stable(vid_dout))) // R3
    else $error("mode or data moved under strobe");
  AST_DONE_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ($past(strobe_on) && !strobe_on)) // R4
    else $error("done pulse not at strobe end");
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    !(!vid_wr_n && !vid_rd_n)) // R7
    else $error("both strobes active");
  AST_STALL_HOLDS_STROBE: assert property (@(posedge clk) disable iff (rst)
    (strobe_on && stall) |=> strobe_on) // R10
    else $error("strobe ended while wait held");
endmodule

// File: tb/sim_vid_access_seq.sv
`timescale 1ns/1ps
module sim_vid_access_seq;
  localparam int STB = 20;    // 100 ns at 200 MHz
  localparam int SG  = 400;   // 2 us
  localparam int LG  = 1600;  // 8 us
  localparam int RC  = 2000;  // 10 us

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [1:0] req_port = 2'd0;
  logic [7:0] req_wdata = 8'd0;
  logic req_ready, rsp_valid, vid_reset_n, vid_wr_n, vid_rd_n;
  logic [7:0] rsp_rdata, vid_dout, vid_din;
  logic [1:0] vid_mode;
  logic vid_wait_n = 1'b1;
  logic [7:0] dev_rd [4];

  always #2.5 clk = ~clk;

  assign vid_din = vid_rd_n ? 8'h00 : dev_rd[vid_mode];

  vid_access_seq u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_port(req_port), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .vid_reset_n(vid_reset_n),
    .vid_wr_n(vid_wr_n), .vid_rd_n(vid_rd_n), .vid_mode(vid_mode),
    .vid_dout(vid_dout), .vid_din(vid_din), .vid_wait_n(vid_wait_n)
  );

  typedef struct { logic is_rd; logic [7:0] d; } item_t;
  item_t expq[$];
  int n_cmp = 0, n_bad = 0, issued = 0, strobes_seen = 0;
  logic [7:0] last_rd = 8'h00;
  logic [1:0] exp_port = 2'd0;
  logic [7:0] exp_data = 8'd0;
  int exp_wmin = STB, exp_wmax = STB;
  string w_tag = "R3";

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Response monitor (scoreboard side)
  item_t it;
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (expq.size() == 0) chk(1'b0, "R5", "done with nothing expected", 1, 0);
      else begin
        it = expq.pop_front();
        if (it.is_rd) chk(rsp_rdata == it.d, "R4", "read data", rsp_rdata, it.d);
        else          chk(rsp_rdata == it.d, "R5", "write left read data", rsp_rdata, it.d);
      end
    end
  end

  // Strobe monitor: widths, gaps, fields
  int lo_cnt = 0, hi_cnt = 0, gap_exp;
  bit prev_on = 0, seen_any = 0;
  logic [1:0] prev_port = 2'd0;
  always @(negedge clk) begin
    if (!rst) begin
      if (!vid_wr_n || !vid_rd_n) begin
        if (!prev_on) begin
          strobes_seen++;
          chk(!(!vid_wr_n && !vid_rd_n), "R7", "both strobes low", 1, 0);
          if (seen_any) begin
            gap_exp = (prev_port == 2'd0) ? LG : SG;
            chk(hi_cnt >= gap_exp, "R6", "recovery gap minimum", hi_cnt, gap_exp);
            chk(hi_cnt == gap_exp + 1, "R6", "gap with waiting request", hi_cnt, gap_exp + 1);
          end
          chk(vid_mode == exp_port, "R3", "mode pins", vid_mode, exp_port);
          if (!vid_wr_n) chk(vid_dout == exp_data, "R3", "write data", vid_dout, exp_data);
          chk(!req_ready, "R2", "ready during strobe", req_ready, 0);
          lo_cnt = 1;
          seen_any = 1;
          prev_port = vid_mode;
        end else lo_cnt++;
        prev_on = 1;
      end else begin
        if (prev_on) begin
          chk(lo_cnt >= exp_wmin && lo_cnt <= exp_wmax, w_tag, "strobe width", lo_cnt, exp_wmin);
          hi_cnt = 1;
        end else hi_cnt++;
        prev_on = 0;
      end
    end
  end

  // Driver: pushes expected result, then runs one access; rel_k>=0 releases wait K cycles in
  task automatic access(input bit wr, input logic [1:0] p, input logic [7:0] d, input int rel_k);
    item_t e;
    exp_port = p;
    exp_data = d;
    e.is_rd = !wr;
    e.d = wr ? last_rd : dev_rd[p];
    if (!wr) last_rd = dev_rd[p];
    expq.push_back(e);
    req_write = wr; req_port = p; req_wdata = d; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    issued++;
    if (rel_k >= 0) begin
      repeat (rel_k) @(negedge clk);
      vid_wait_n = 1'b1;
    end
    while (!vid_wr_n || !vid_rd_n) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic set_w(input string tag, input int mn, input int mx);
    w_tag = tag; exp_wmin = mn; exp_wmax = mx;
  endtask

  int rcnt;
  bit rdy_seen;
  initial begin
    dev_rd[0] = 8'h3C; dev_rd[1] = 8'h9F; dev_rd[2] = 8'h11; dev_rd[3] = 8'h6E;
    repeat (5) @(negedge clk);
    chk(vid_wr_n && vid_rd_n && !vid_reset_n, "R1", "outputs in reset", {vid_wr_n, vid_rd_n, vid_reset_n}, 3'b110);
    rst = 1'b0;
    rcnt = 0; rdy_seen = 0;
    while (!vid_reset_n) begin
      rcnt++;
      if (req_ready || !vid_wr_n || !vid_rd_n) rdy_seen = 1;
      @(negedge clk);
    end
    chk(rcnt == RC, "R1", "device reset low cycles", rcnt, RC);
    chk(!rdy_seen, "R1", "ready or strobe during reset", rdy_seen, 0);
    chk(req_ready, "R1", "ready after reset pulse", req_ready, 1);

    // R3/R4/R5/R6: plain accesses across ports
    set_w("R3", STB, STB);
    access(1, 2'd0, 8'hA5, -1);
    set_w("R4", STB, STB);
    access(0, 2'd0, 8'h00, -1);
    access(0, 2'd1, 8'h00, -1);
    access(0, 2'd2, 8'h00, -1);
    set_w("R3", STB, STB);
    access(1, 2'd2, 8'h5A, -1);
    access(1, 2'd3, 8'hC3, -1);
    dev_rd[3] = 8'h81;
    set_w("R4", STB, STB);
    access(0, 2'd3, 8'h00, -1);

    // R9: wait disabled, line low is ignored
    vid_wait_n = 1'b0;
    set_w("R9", STB, STB);
    access(1, 2'd2, 8'h77, -1);
    dev_rd[0] = 8'hE4;
    access(0, 2'd0, 8'h00, -1);
    vid_wait_n = 1'b1;

    // R8: enable through register 25 pair
    set_w("R3", STB, STB);
    access(1, 2'd1, 8'h04, -1);
    access(1, 2'd1, 8'h99, -1);
    // R10: stretched strobes
    vid_wait_n = 1'b0;
    set_w("R10", STB + 10, STB + 12);
    access(1, 2'd2, 8'h42, 10);
    vid_wait_n = 1'b0;
    dev_rd[0] = 8'h2B;
    set_w("R10", STB, STB + 2);
    access(0, 2'd0, 8'h00, 0);

    // R8: pair naming register 24 leaves wait enabled
    set_w("R3", STB, STB);
    access(1, 2'd1, 8'h00, -1);
    access(1, 2'd1, 8'h98, -1);
    vid_wait_n = 1'b0;
    set_w("R8", STB + 5, STB + 7);
    access(1, 2'd3, 8'h10, 5);

    // R8: disable through register 25 pair, then R9 again
    set_w("R3", STB, STB);
    access(1, 2'd1, 8'h00, -1);
    access(1, 2'd1, 8'h99, -1);
    vid_wait_n = 1'b0;
    set_w("R9", STB, STB);
    access(1, 2'd2, 8'h33, -1);
    vid_wait_n = 1'b1;

    // R8: status read restarts pairing
    set_w("R3", STB, STB);
    access(1, 2'd1, 8'h04, -1);
    dev_rd[1] = 8'h1F;
    set_w("R4", STB, STB);
    access(0, 2'd1, 8'h00, -1);
    set_w("R3", STB, STB);
    access(1, 2'd1, 8'h04, -1);
    access(1, 2'd1, 8'h99, -1);
    vid_wait_n = 1'b0;
    set_w("R8", STB + 7, STB + 9);
    access(1, 2'd2, 8'h01, 7);

    repeat (5) @(negedge clk);
    chk(strobes_seen == issued, "R2", "strobes versus requests taken", strobes_seen, issued);
    chk(expq.size() == 0, "R4", "responses outstanding", expq.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog R2 run did not finish actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule